// File: doc/BRIEF.md
# Processor Status and Trap-Entry Register

This block keeps the mode and control state of a small processor core in one 32-bit status word. The word holds a supervisor flag, a saved previous-supervisor flag, a trap enable, an eight-bit interrupt mask, a 64-bit-mode bit for each privilege level, a virtual-memory enable, and three optional-unit enables for floating point, vector and compressed code. Software replaces the word with a write. A trap-entry event rewrites the word on its own: it moves to supervisor mode, saves the old supervisor flag and turns traps off, in one cycle.

Every value that reaches the register first goes through a mask. The mask is built from the build parameters, so bits for features that are not present can never be set. The block drives the integer register width, the virtual-memory enable and the supervisor flag toward the memory unit. It also gives a one-cycle flush request after each update. On a trap it stores the faulting PC and the bad virtual address reported by the memory unit. The exception vector register comes out of reset at 0x2000.

Top module: `mode_status_reg`

## Requirements
- R1: Status bit layout: trap enable bit 0, FPU enable bit 1, vector enable bit 2, compressed enable bit 3, previous-supervisor bit 4, supervisor bit 5, user-64 bit 6, supervisor-64 bit 7, virtual-memory bit 8, interrupt mask bits 23:16. All other bits (15:9 and 31:24) always read as zero. A write with no trap stores the written value with those bits cleared, and `status` reads back exactly the stored value.
- R2: When the 64-bit parameter is off, bits 7 and 6 are stored as zero, whatever the write or trap.
- R3: When the FPU, vector or compressed parameter is off, bit 1, 2 or 3 respectively is stored as zero.
- R4: After reset, `status` holds bits 5, 7, 0 and 23:16 set and all else clear (0x00FF00A1, or 0x00FF0021 without 64-bit support). `evec` is 0x2000, `epc` and `badva` are zero, and `tlb_flush` is low.
- R5: `xpr_width` is 64 when the active mode's 64-bit bit is set and 32 otherwise. The active bit is bit 7 when bit 5 is set, and bit 6 when bit 5 is clear.
- R6: One cycle after `trap_take`, bit 0 is clear, bit 5 is set, bit 4 equals the former bit 5, and every other bit is unchanged.
- R7: One cycle after `trap_take`, `epc` holds the `trap_pc` and `badva` holds the `mmu_badva` presented with it. Neither register changes without a trap.
- R8: `vm_on` follows bit 8 and `sup_mode` follows bit 5 of the stored word. `tlb_flush` is high for exactly the one cycle after each write or trap, and low otherwise. Without an update the stored word is stable.
- R9: When `trap_take` and `wr_en` are both high in the same cycle, the trap update is applied and the write data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe for the status word |
| wr_data | input | 32 | Status value to write |
| trap_take | input | 1 | Trap-entry event |
| trap_pc | input | PC_W | PC of the trapping instruction |
| mmu_badva | input | PC_W | Faulting virtual address from the memory unit |
| status | output | 32 | Stored, sanitized status word |
| xpr_width | output | 7 | Effective integer register width (32 or 64) |
| vm_on | output | 1 | Virtual-memory enable toward the memory unit |
| sup_mode | output | 1 | Supervisor flag toward the memory unit |
| tlb_flush | output | 1 | One-cycle translation flush request after an update |
| epc | output | PC_W | Captured exception PC |
| badva | output | PC_W | Captured bad virtual address |
| evec | output | PC_W | Exception vector base |

## Verification
The assertions assume that the strobes are clean single-bit levels, sampled at the clock edge. They also assume that `wr_data`, `trap_pc` and `mmu_badva` are meaningful only in the cycle when their strobe is high. The bench drives every input at the falling edge and pulses each strobe for one cycle. A quiet cycle often follows a pulse, so the flush pulse can be seen to fall and the stored word to stay put. The write sweep covers all 512 combinations of the nine low control bits, with varied mask and reserved-bit contents. It runs on two builds with opposite feature sets. Traps are issued from both supervisor and user states, and once together with a write.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    localparam int STAT_W = 32;

    localparam int B_ET = 0;
    localparam int B_EF = 1;
    localparam int B_EV = 2;
    localparam int B_EC = 3;
    localparam int B_PS = 4;
    localparam int B_S  = 5;
    localparam int B_UX = 6;
    localparam int B_SX = 7;
    localparam int B_VM = 8;
    localparam int IM_LO = 16;
    localparam int IM_W  = 8;

    typedef logic [STAT_W-1:0] stat_t;

    localparam stat_t IM_FIELD = stat_t'(((1 << IM_W) - 1) << IM_LO);
    localparam stat_t DEFINED  = IM_FIELD | stat_t'((1 << (B_VM + 1)) - 1);

endpackage

// File: rtl/mstat_sanitize.sv
module mstat_sanitize
    import mstat_pkg::*;
#(
    parameter bit X64_EN = 1'b1,
    parameter bit FPU_EN = 1'b1,
    parameter bit RVC_EN = 1'b1,
    parameter bit VEC_EN = 1'b1
) (
    input  stat_t raw,
    output stat_t clean
);

    stat_t drop;

    generate
        if (X64_EN) begin : g_x64
            assign drop[B_SX] = 1'b0;
            assign drop[B_UX] = 1'b0;
        end else begin : g_x32
            assign drop[B_SX] = 1'b1;
            assign drop[B_UX] = 1'b1;
        end
    endgenerate

    assign drop[B_EF] = !FPU_EN;
    assign drop[B_EV] = !VEC_EN;
    assign drop[B_EC] = !RVC_EN;
    assign drop[B_ET] = 1'b0;
    assign drop[B_PS] = 1'b0;
    assign drop[B_S]  = 1'b0;
    assign drop[B_VM] = 1'b0;
    assign drop[STAT_W-1:B_VM+1] = '0;

    assign clean = raw & DEFINED & ~drop;

endmodule

// File: rtl/mstat_width_sel.sv
module mstat_width_sel
    import mstat_pkg::*;
(
    input  stat_t      st,
    output logic       wide,
    output logic [6:0] xpr_width
);

    always_comb begin
        wide      = st[B_S] ? st[B_SX] : st[B_UX];
        xpr_width = wide ? 7'd64 : 7'd32;
    end

endmodule

// File: rtl/mode_status_reg.sv
module mode_status_reg
    import mstat_pkg::*;
#(
    parameter int              PC_W     = 64,
    parameter bit              X64_EN   = 1'b1,
    parameter bit              FPU_EN   = 1'b1,
    parameter bit              RVC_EN   = 1'b1,
    parameter bit              VEC_EN   = 1'b1,
    parameter logic [PC_W-1:0] EVEC_RST = PC_W'('h2000)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [31:0]     wr_data,
    input  logic            trap_take,
    input  logic [PC_W-1:0] trap_pc,
    input  logic [PC_W-1:0] mmu_badva,
    output logic [31:0]     status,
    output logic [6:0]      xpr_width,
    output logic            vm_on,
    output logic            sup_mode,
    output logic            tlb_flush,
    output logic [PC_W-1:0] epc,
    output logic [PC_W-1:0] badva,
    output logic [PC_W-1:0] evec
);

    typedef struct packed {
        stat_t           stat;
        logic [PC_W-1:0] epc;
        logic [PC_W-1:0] badva;
        logic [PC_W-1:0] evec;
        logic            flush;
    } state_t;

    localparam stat_t RST_RAW = IM_FIELD
                              | stat_t'(1 << B_S)
                              | stat_t'(1 << B_SX)
                              | stat_t'(1 << B_ET);

    state_t state_d, state_q;
    stat_t  trap_raw, upd_raw, upd_clean, rst_clean;
    logic   wide_unused;

    // Trap entry: leave trap-enable off, enter supervisor, keep old supervisor
    always_comb begin
        trap_raw       = state_q.stat;
        trap_raw[B_ET] = 1'b0;
        trap_raw[B_PS] = state_q.stat[B_S];
        trap_raw[B_S]  = 1'b1;
        upd_raw        = trap_take ? trap_raw : stat_t'(wr_data);
    end

    mstat_sanitize #(
        .X64_EN(X64_EN), .FPU_EN(FPU_EN), .RVC_EN(RVC_EN), .VEC_EN(VEC_EN)
    ) u_upd_mask (
        .raw   (upd_raw),
        .clean (upd_clean)
    );

    mstat_sanitize #(
        .X64_EN(X64_EN), .FPU_EN(FPU_EN), .RVC_EN(RVC_EN), .VEC_EN(VEC_EN)
    ) u_rst_mask (
        .raw   (RST_RAW),
        .clean (rst_clean)
    );

    always_comb begin
        state_d       = state_q;
        state_d.flush = 1'b0;
        if (trap_take) begin
            state_d.stat  = upd_clean;
            state_d.epc   = trap_pc;
            state_d.badva = mmu_badva;
            state_d.flush = 1'b1;
        end else if (wr_en) begin
            state_d.stat  = upd_clean;
            state_d.flush = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.stat  <= rst_clean;
            state_q.epc   <= '0;
            state_q.badva <= '0;
            state_q.evec  <= EVEC_RST;
            state_q.flush <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    mstat_width_sel u_width (
        .st        (state_q.stat),
        .wide      (wide_unused),
        .xpr_width (xpr_width)
    );

    assign status    = state_q.stat;
    assign vm_on     = state_q.stat[B_VM];
    assign sup_mode  = state_q.stat[B_S];
    assign tlb_flush = state_q.flush;
    assign epc       = state_q.epc;
    assign badva     = state_q.badva;
    assign evec      = state_q.evec;

endmodule

// File: rtl/mstat_chk.sv
module mstat_chk
    import mstat_pkg::*;
#(
    parameter int PC_W   = 64,
    parameter bit X64_EN = 1'b1,
    parameter bit FPU_EN = 1'b1,
    parameter bit RVC_EN = 1'b1,
    parameter bit VEC_EN = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [31:0]     wr_data,
    input logic            trap_take,
    input logic [PC_W-1:0] trap_pc,
    input logic [PC_W-1:0] mmu_badva,
    input logic [31:0]     status,
    input logic [6:0]      xpr_width,
    input logic            vm_on,
    input logic            sup_mode,
    input logic            tlb_flush,
    input logic [PC_W-1:0] epc,
    input logic [PC_W-1:0] badva
);

    localparam logic [31:0] KEEP = 32'h00FF_01FF
        & ~(X64_EN ? 32'h0 : 32'hC0)
        & ~(FPU_EN ? 32'h0 : 32'h2)
        & ~(VEC_EN ? 32'h0 : 32'h4)
        & ~(RVC_EN ? 32'h0 : 32'h8);

    // R1
    write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !trap_take) |=> status == ($past(wr_data) & KEEP));

    // R2
    no_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !X64_EN |-> (status[B_SX] == 1'b0 && status[B_UX] == 1'b0));

    // R5
    width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xpr_width == (((status[B_S] && status[B_SX]) || (!status[B_S] && status[B_UX])) ? 7'd64 : 7'd32));

    // R6
    trap_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (!status[B_ET] && status[B_S] && status[B_PS] == $past(status[B_S])));

    // R7
    trap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (epc == $past(trap_pc) && badva == $past(mmu_badva)));

    // R7
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_take |=> ($stable(epc) && $stable(badva)));

    // R8
    flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || trap_take) |=> tlb_flush);

    // R8
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en || trap_take) |=> (!tlb_flush && $stable(status)));

    // R8
    mmu_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vm_on == status[B_VM] && sup_mode == status[B_S]));

    // R9
    trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && wr_en) |=> (!status[B_ET] && epc == $past(trap_pc)));

endmodule

bind mode_status_reg mstat_chk #(
    .PC_W(PC_W), .X64_EN(X64_EN), .FPU_EN(FPU_EN), .RVC_EN(RVC_EN), .VEC_EN(VEC_EN)
) u_mstat_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .trap_take(trap_take), .trap_pc(trap_pc), .mmu_badva(mmu_badva),
    .status(status), .xpr_width(xpr_width), .vm_on(vm_on), .sup_mode(sup_mode),
    .tlb_flush(tlb_flush), .epc(epc), .badva(badva)
);

// File: tb/mode_status_reg_bench.sv
`timescale 1ns/1ps
module mode_status_reg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        trap_take = 1'b0;
    logic [63:0] trap_pc = '0;
    logic [63:0] mmu_badva = '0;

    logic [31:0] st_a, st_b;
    logic [6:0]  w_a, w_b;
    logic        vm_a, vm_b, sup_a, sup_b, fl_a, fl_b;
    logic [63:0] epc_a, epc_b, bva_a, bva_b, evec_a, evec_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] ea, eb;
    logic [63:0] e_epc, e_bva;
    logic        e_flush;

    always #2 clk = ~clk;

    // Build A: 64-bit on, FPU off, compressed on, vector off
    mode_status_reg #(.PC_W(64), .X64_EN(1'b1), .FPU_EN(1'b0), .RVC_EN(1'b1), .VEC_EN(1'b0))
    u_mode_status_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .trap_take(trap_take), .trap_pc(trap_pc), .mmu_badva(mmu_badva),
        .status(st_a), .xpr_width(w_a), .vm_on(vm_a), .sup_mode(sup_a),
        .tlb_flush(fl_a), .epc(epc_a), .badva(bva_a), .evec(evec_a)
    );

    // Build B: 64-bit off, FPU on, compressed off, vector on
    mode_status_reg #(.PC_W(64), .X64_EN(1'b0), .FPU_EN(1'b1), .RVC_EN(1'b0), .VEC_EN(1'b1))
    u_mode_status_reg_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .trap_take(trap_take), .trap_pc(trap_pc), .mmu_badva(mmu_badva),
        .status(st_b), .xpr_width(w_b), .vm_on(vm_b), .sup_mode(sup_b),
        .tlb_flush(fl_b), .epc(epc_b), .badva(bva_b), .evec(evec_b)
    );

    function automatic logic [31:0] keep_of(bit x64, bit fpu, bit rvc, bit vec);
        logic [31:0] k;
        k = 32'h00FF_01FF;
        if (!x64) k = k & ~32'hC0;
        if (!fpu) k = k & ~32'h02;
        if (!vec) k = k & ~32'h04;
        if (!rvc) k = k & ~32'h08;
        return k;
    endfunction

    function automatic logic [31:0] trap_of(logic [31:0] s);
        logic [31:0] t;
        t = s;
        t[0] = 1'b0;
        t[4] = s[5];
        t[5] = 1'b1;
        return t;
    endfunction

    function automatic logic [63:0] width_of(logic [31:0] s);
        return (s[5] ? s[7] : s[6]) ? 64'd64 : 64'd32;
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic op(input logic w, input logic [31:0] d, input logic t,
                      input logic [63:0] pc, input logic [63:0] bv);
        logic [31:0] ka, kb;
        ka = keep_of(1'b1, 1'b0, 1'b1, 1'b0);
        kb = keep_of(1'b0, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        wr_en = w; wr_data = d; trap_take = t; trap_pc = pc; mmu_badva = bv;
        if (t) begin
            ea = trap_of(ea) & ka;
            eb = trap_of(eb) & kb;
            e_epc = pc;
            e_bva = bv;
        end else if (w) begin
            ea = d & ka;
            eb = d & kb;
        end
        e_flush = w | t;
        @(negedge clk);
        wr_en = 1'b0; trap_take = 1'b0;
    endtask

    task automatic verify(string req);
        check(req, "status A", st_a, ea);
        check(req, "status B", st_b, eb);
        check("R5", "width A", w_a, width_of(ea));
        check("R5", "width B", w_b, width_of(eb));
        check("R8", "vm/sup A", {vm_a, sup_a}, {ea[8], ea[5]});
        check("R8", "vm/sup B", {vm_b, sup_b}, {eb[8], eb[5]});
        check("R8", "flush A", fl_a, e_flush);
        check("R8", "flush B", fl_b, e_flush);
        check("R7", "epc A", epc_a, e_epc);
        check("R7", "badva B", bva_b, e_bva);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 reset state
        ea = 32'h00FF_00A1; eb = 32'h00FF_0021;
        e_epc = '0; e_bva = '0; e_flush = 1'b0;
        check("R4", "reset status A", st_a, ea);
        check("R4", "reset status B", st_b, eb);
        check("R4", "reset evec", evec_a, 64'h2000);
        check("R4", "reset evec B", evec_b, 64'h2000);
        check("R4", "reset flush", fl_a, 1'b0);
        check("R4", "reset epc/badva", {epc_a, bva_a}, '0);
        check("R4", "reset width A", w_a, 64'd64);
        check("R4", "reset width B", w_b, 64'd32);

        // R1 R2 R3: sweep the nine low control bits with varied upper content
        for (int i = 0; i < 512; i++) begin
            logic [31:0] d;
            d = {8'(i * 37 + 1), 8'(i ^ 8'h5A), 7'(i * 3 + 1), 9'(i)};
            op(1'b1, d, 1'b0, '0, '0);
            verify("R1");
            check("R2", "wide bits B", {56'd0, st_b[7:6]}, 64'd0);
            check("R3", "feature bits A", {st_a[3], st_a[2], st_a[1]}, {d[3], 1'b0, 1'b0});
            check("R3", "feature bits B", {st_b[3], st_b[2], st_b[1]}, {1'b0, d[2], d[1]});
            if (i % 64 == 0) begin
                op(1'b0, 32'hFFFF_FFFF, 1'b0, '0, '0);
                verify("R8");
            end
        end

        // R6 R7: traps from user and supervisor states
        for (int j = 0; j < 8; j++) begin
            logic [31:0] d;
            d = {8'h00, 8'(8'h11 << j), 7'h00, 9'(j * 73 + 1)};
            op(1'b1, d, 1'b0, '0, '0);
            op(1'b0, '0, 1'b1, 64'hF000_0000_0000_0100 + 64'(j * 4),
               64'h0000_7FFF_0000_0000 | 64'(j));
            verify("R6");
            check("R6", "PS A", st_a[4], d[5]);
            check("R7", "epc B", epc_b, e_epc);
            check("R7", "badva A", bva_a, e_bva);
            op(1'b0, '0, 1'b1, 64'h1234, 64'h5678);
            verify("R6");
            check("R6", "PS after nested A", st_a[4], 1'b1);
        end

        // R7: capture registers hold without a trap
        op(1'b1, 32'h0000_0160, 1'b0, 64'hDEAD, 64'hBEEF);
        verify("R7");
        op(1'b0, '0, 1'b0, 64'hCAFE, 64'hF00D);
        verify("R7");

        // R9: trap and write together, trap wins
        op(1'b1, 32'h0000_0040, 1'b0, '0, '0);
        op(1'b1, 32'hFFFF_FFFF, 1'b1, 64'hABCD_0000, 64'h0000_1357);
        verify("R9");
        check("R9", "write discarded A", st_a, 32'h0000_0060);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule